// File: doc/BRIEF.md
# Multi-Core Interrupt Aggregator

This block gathers level-sensitive hardware interrupt lines and software-raised pending bits for a small multi-core cluster. It holds a mask bit and a core-routing word for each line, plus one inter-processor interrupt channel per core. Each core sees its own interrupt output and drains its work by reading one event register again and again. Each read reports the next source that qualifies for that core, as a type and a number.

A read that returns a source also masks that source. Software has to unmask it once it has serviced it. Access uses a 32-bit register bus: a valid strobe, a write flag, a 16-bit byte address, write data and the ID of the accessing core. Read data is combinational in the cycle of the access. All side effects of an access take place at the clock edge that ends it. The core count and the line count are parameters. The line count must be a multiple of 32.

Top module: `irq_aggregator`

## Requirements
- R1: A read of address 0x0004 returns the line count in bits 15:0, with the upper bits zero. A read of 0x2000 returns the ID of the accessing core.
- R2: After reset every line is masked, no software-pending bit is set, every routing word is zero, no IPI is pending and every IPI mask is clear. Every `core_irq` bit is 0, and event reads return 0.
- R3: The routing word of line n is at 0x3000 + 4n. Bit c routes the line to core c, and the word reads back what was written. Bits at or above the core count read as 0.
- R4: Each bank holds one 32-bit word per 32 lines, at bank base + 4*(n/32), with line n at bit n mod 32. The banks are: software-pending set at 0x4000, software-pending clear at 0x4080, mask set at 0x4100 and mask clear at 0x4180. A 1 written to a bit sets or clears it, and a 0 leaves it unchanged. Either pending bank reads back the pending word, and either mask bank reads back the mask word.
- R5: A line qualifies for core c only when it is (hardware-high or software-pending), and unmasked, and routed to c.
- R6: A read of the event register at 0x2004 returns the type in bits 31:16 and the number in bits 15:0. Type 1 with the line number means the lowest-numbered line that qualifies for the reading core.
- R7: An event read that returns line n sets the mask bit of line n. The next read then reports the next qualifying line.
- R8: A write to 0x2008 raises an IPI at every core whose bit is set in the write data. A pending, unmasked IPI is reported first, before any line, as type 4 with number 1.
- R9: An event read that returns an IPI sets the IPI mask of the reading core. Writing bit 0 to 0x2028 clears that mask for the accessing core. Writing bit 0 to 0x200C clears the pending IPI of the accessing core.
- R10: `core_irq[c]` is high exactly while core c has a qualifying line or a pending unmasked IPI.
- R11: An event read with nothing qualifying returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_line | input | NUM_LINES | Level-sensitive hardware interrupt lines |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_core | input | CORE_W | ID of the accessing core |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| core_irq | output | NUM_CORES | Per-core interrupt request |

## Verification
The assertions assume that only one access happens per cycle and that `bus_core` names a core that exists. They also assume that the hardware lines do not change in the cycle of an event read. Under those conditions, a reported line is masked at the next edge and a core with a low request reads a zero event. The stimulus drives every access at the falling edge and holds it for one full cycle. It uses only core IDs below the core count, and it changes `hw_line` only between accesses.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam logic [15:0] EV_NONE = 16'd0;
   localparam logic [15:0] EV_LINE = 16'd1;
   localparam logic [15:0] EV_IPI  = 16'd4;

   localparam logic [15:0] A_INFO     = 16'h0004;
   localparam logic [15:0] A_WHOAMI   = 16'h2000;
   localparam logic [15:0] A_EVENT    = 16'h2004;
   localparam logic [15:0] A_IPI_SEND = 16'h2008;
   localparam logic [15:0] A_IPI_ACK  = 16'h200C;
   localparam logic [15:0] A_IPI_UNMK = 16'h2028;
   localparam logic [3:0]  ROUTE_PAGE = 4'h3;
   localparam logic [6:0]  BANK_PAGE  = 7'h20;   // 0x4000 >> 9

   localparam logic [1:0] BK_PEND_SET = 2'd0;
   localparam logic [1:0] BK_PEND_CLR = 2'd1;
   localparam logic [1:0] BK_MASK_SET = 2'd2;
   localparam logic [1:0] BK_MASK_CLR = 2'd3;
endpackage

// File: rtl/irq_first_set.sv
module irq_first_set #(
   parameter int W     = 64,
   parameter int IDX_W = 6
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_core_view.sv
module irq_core_view
   import irq_agg_pkg::*;
#(
   parameter int NUM_LINES = 64,
   parameter int LINE_W    = 6
) (
   input  logic [NUM_LINES-1:0] live,
   input  logic [NUM_LINES-1:0] routed,
   input  logic                 ipi_live,
   output logic [15:0]          ev_kind,
   output logic [15:0]          ev_num,
   output logic                 irq
);
   logic [NUM_LINES-1:0] qual;
   logic                 any_line;
   logic [LINE_W-1:0]    first;

   assign qual = live & routed;

   irq_first_set #(.W(NUM_LINES), .IDX_W(LINE_W)) u_first (
      .vec(qual), .found(any_line), .idx(first)
   );

   always_comb begin
      if (ipi_live) begin
         ev_kind = EV_IPI;
         ev_num  = 16'd1;
      end else if (any_line) begin
         ev_kind = EV_LINE;
         ev_num  = 16'(first);
      end else begin
         ev_kind = EV_NONE;
         ev_num  = 16'd0;
      end
   end

   assign irq = ipi_live | any_line;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_LINES = 64,
   localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int LINE_W   = $clog2(NUM_LINES),
   localparam int WORDS    = NUM_LINES / 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] hw_line,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic [15:0]          bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [CORE_W-1:0]    bus_core,
   output logic [31:0]          bus_rdata,
   output logic [NUM_CORES-1:0] core_irq
);
   if (NUM_LINES % 32 != 0 || NUM_LINES < 32 || NUM_LINES > 1024) begin : g_bad_lines
      $error("NUM_LINES must be a multiple of 32 in 32..1024");
   end
   if (NUM_CORES < 1 || NUM_CORES > 32) begin : g_bad_cores
      $error("NUM_CORES must be in 1..32");
   end

   logic [NUM_LINES-1:0] mask_q, swp_q;
   logic [NUM_CORES-1:0] route_q [NUM_LINES];
   logic [NUM_CORES-1:0] ipi_pend_q, ipi_mask_q;

   logic [NUM_LINES-1:0] live;
   logic [15:0]          ev_kind [NUM_CORES];
   logic [15:0]          ev_num  [NUM_CORES];

   assign live = (hw_line | swp_q) & ~mask_q;

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [NUM_LINES-1:0] col;
      always_comb begin
         for (int n = 0; n < NUM_LINES; n++) col[n] = route_q[n][c];
      end
      irq_core_view #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_view (
         .live(live), .routed(col),
         .ipi_live(ipi_pend_q[c] & ~ipi_mask_q[c]),
         .ev_kind(ev_kind[c]), .ev_num(ev_num[c]), .irq(core_irq[c])
      );
   end

   // address decode
   logic              rd, wr, core_ok, route_hit, bank_hit;
   logic [LINE_W-1:0] route_idx;
   logic [1:0]        bank_sel;
   int                bank_lsb;
   logic [15:0]       my_kind, my_num;

   assign rd        = bus_valid & ~bus_write;
   assign wr        = bus_valid & bus_write;
   assign core_ok   = (int'(bus_core) < NUM_CORES);
   assign route_hit = (bus_addr[15:12] == ROUTE_PAGE) &&
                      ({4'b0, bus_addr[11:0]} < 16'(4 * NUM_LINES));
   assign route_idx = bus_addr[LINE_W+1:2];
   assign bank_hit  = (bus_addr[15:9] == BANK_PAGE) && (int'(bus_addr[6:2]) < WORDS);
   assign bank_sel  = bus_addr[8:7];
   assign bank_lsb  = 32 * int'(bus_addr[6:2]);
   assign my_kind   = core_ok ? ev_kind[bus_core] : EV_NONE;
   assign my_num    = core_ok ? ev_num[bus_core]  : 16'd0;

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         if (bus_addr == A_INFO)        bus_rdata = {16'd0, 16'(NUM_LINES)};
         else if (bus_addr == A_WHOAMI) bus_rdata = 32'(bus_core);
         else if (bus_addr == A_EVENT)  bus_rdata = {my_kind, my_num};
         else if (route_hit)            bus_rdata = 32'(route_q[route_idx]);
         else if (bank_hit)
            bus_rdata = bank_sel[1] ? mask_q[bank_lsb +: 32] : swp_q[bank_lsb +: 32];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q     <= '1;
         swp_q      <= '0;
         ipi_pend_q <= '0;
         ipi_mask_q <= '0;
         for (int n = 0; n < NUM_LINES; n++) route_q[n] <= '0;
      end else if (wr) begin
         if (bus_addr == A_IPI_SEND)
            ipi_pend_q <= ipi_pend_q | bus_wdata[NUM_CORES-1:0];
         else if (bus_addr == A_IPI_ACK && bus_wdata[0] && core_ok)
            ipi_pend_q[bus_core] <= 1'b0;
         else if (bus_addr == A_IPI_UNMK && bus_wdata[0] && core_ok)
            ipi_mask_q[bus_core] <= 1'b0;
         else if (route_hit)
            route_q[route_idx] <= bus_wdata[NUM_CORES-1:0];
         else if (bank_hit) begin
            for (int b = 0; b < 32; b++) begin
               if (bus_wdata[b]) begin
                  case (bank_sel)
                     BK_PEND_SET: swp_q[bank_lsb + b]  <= 1'b1;
                     BK_PEND_CLR: swp_q[bank_lsb + b]  <= 1'b0;
                     BK_MASK_SET: mask_q[bank_lsb + b] <= 1'b1;
                     default:     mask_q[bank_lsb + b] <= 1'b0;
                  endcase
               end
            end
         end
      end else if (rd && bus_addr == A_EVENT && core_ok) begin
         if (my_kind == EV_IPI)       ipi_mask_q[bus_core]       <= 1'b1;
         else if (my_kind == EV_LINE) mask_q[my_num[LINE_W-1:0]] <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
   import irq_agg_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int NUM_LINES = 64,
   localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_valid,
   input logic                 bus_write,
   input logic [15:0]          bus_addr,
   input logic [CORE_W-1:0]    bus_core,
   input logic [31:0]          bus_rdata,
   input logic [NUM_CORES-1:0] core_irq,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_CORES-1:0] ipi_mask_q
);
   logic ev_rd;
   assign ev_rd = bus_valid && !bus_write && bus_addr == A_EVENT;

   assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> core_irq == '0);

   assert_line_automask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata[31:16] == EV_LINE) |=> mask_q[$past(bus_rdata[LINE_W-1:0])]);

   assert_ipi_automask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata[31:16] == EV_IPI) |=> ipi_mask_q[$past(bus_core)]);

   assert_ipi_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata[31:16] == EV_IPI) |-> bus_rdata[15:0] == 16'd1);

   assert_idle_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && !core_irq[bus_core]) |-> bus_rdata == 32'd0);

   assert_event_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rd |-> (bus_rdata[31:16] == EV_NONE || bus_rdata[31:16] == EV_LINE ||
                 bus_rdata[31:16] == EV_IPI));

   assert_none_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rd && bus_rdata[31:16] == EV_NONE) |-> bus_rdata[15:0] == 16'd0);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_addr(bus_addr), .bus_core(bus_core), .bus_rdata(bus_rdata),
   .core_irq(core_irq), .mask_q(mask_q), .ipi_mask_q(ipi_mask_q)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
   localparam int NC = 4;
   localparam int NL = 64;
   localparam int CW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] hw = '0;
   logic          bus_valid = 1'b0, bus_write = 1'b0;
   logic [15:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [CW-1:0] bus_core = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] core_irq;

   always #2.5 clk = ~clk;

   irq_aggregator #(.NUM_CORES(NC), .NUM_LINES(NL)) u0 (
      .clk(clk), .rst_n(rst_n), .hw_line(hw), .bus_valid(bus_valid),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_core(bus_core), .bus_rdata(bus_rdata), .core_irq(core_irq)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // reference state, maintained from the requirement text
   logic [NL-1:0] m_mask = '1, m_sw = '0;
   logic [NC-1:0] m_route [NL];
   logic [NC-1:0] m_ipi = '0, m_ipim = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_event(input int c);
      if (m_ipi[c] && !m_ipim[c]) return {16'd4, 16'd1};
      for (int n = 0; n < NL; n++)
         if ((hw[n] | m_sw[n]) && !m_mask[n] && m_route[n][c]) return {16'd1, 16'(n)};
      return 32'd0;
   endfunction

   function automatic logic [NC-1:0] exp_irq();
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++) r[c] = (exp_event(c) != 0);
      return r;
   endfunction

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input int c);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_core = CW'(c);
      @(negedge clk);
      bus_valid = 0; bus_write = 0;
      // mirror into the reference
      if (a == 16'h2008) m_ipi = m_ipi | d[NC-1:0];
      else if (a == 16'h200C && d[0]) m_ipi[c] = 0;
      else if (a == 16'h2028 && d[0]) m_ipim[c] = 0;
      else if (a >= 16'h3000 && a < 16'h3000 + 4*NL) m_route[(a-16'h3000)/4] = d[NC-1:0];
      else if (a >= 16'h4000 && a < 16'h4200) begin
         for (int b = 0; b < 32; b++) if (d[b]) begin
            int idx = 32 * int'(a[6:2]) + b;
            case (a[8:7])
               2'd0: m_sw[idx] = 1;
               2'd1: m_sw[idx] = 0;
               2'd2: m_mask[idx] = 1;
               default: m_mask[idx] = 0;
            endcase
         end
      end
   endtask

   task automatic rd(input logic [15:0] a, input int c, output logic [31:0] q);
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = a; bus_core = CW'(c);
      #1 q = bus_rdata;
      @(negedge clk);
      bus_valid = 0;
   endtask

   task automatic ev(input int c, input string req);
      logic [31:0] q, e;
      e = exp_event(c);
      rd(16'h2004, c, q);
      chk(req, q, e);
      if (e[31:16] == 16'd4) m_ipim[c] = 1;
      else if (e[31:16] == 16'd1) m_mask[e[5:0]] = 1;
   endtask

   task automatic irq_chk(input string req);
      #1 chk(req, 32'(core_irq), 32'(exp_irq()));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] q;
      for (int n = 0; n < NL; n++) m_route[n] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // reset state and identity
      irq_chk("R2 reset irq");
      chk("R2 reset irq zero", 32'(core_irq), 32'd0);
      rd(16'h0004, 0, q); chk("R1 line count", q, 32'd64);
      for (int c = 0; c < NC; c++) begin
         rd(16'h2000, c, q); chk("R1 whoami", q, 32'(c));
         ev(c, "R2 R11 idle event");
      end
      for (int w = 0; w < NL/32; w++) begin
         rd(16'(16'h4100 + 4*w), 0, q); chk("R2 mask word reset", q, 32'hFFFF_FFFF);
         rd(16'(16'h4000 + 4*w), 0, q); chk("R2 pending word reset", q, 32'd0);
      end
      rd(16'h3000 + 16'(4*17), 0, q); chk("R2 route reset", q, 32'd0);

      // every line through the hardware path, one core at a time
      for (int n = 0; n < NL; n++) begin
         int c = n % NC;
         wr(16'(16'h3000 + 4*n), 32'hFFFF_FFF0 | (32'd1 << c), 0);
         rd(16'(16'h3000 + 4*n), 0, q); chk("R3 route readback", q, 32'd1 << c);
         hw[n] = 1;
         irq_chk("R5 masked line stays quiet");
         wr(16'(16'h4180 + 4*(n/32)), 32'd1 << (n%32), c);
         rd(16'(16'h4180 + 4*(n/32)), 0, q);
         chk("R4 mask clear bit", q, m_mask[32*(n/32) +: 32]);
         irq_chk("R10 irq follows line");
         ev((c + 1) % NC, "R5 unrouted core sees nothing");
         ev(c, "R6 event reports line");
         rd(16'(16'h4100 + 4*(n/32)), 0, q);
         chk("R7 mask set by event read", q[n%32], 1'b1);
         irq_chk("R10 irq drops after read");
         ev(c, "R11 drained");
         hw[n] = 0;
      end

      // software-pending path, ascending order of delivery
      for (int n = 3; n < NL; n += 7) begin
         wr(16'(16'h3000 + 4*n), 32'd2, 0);
         wr(16'(16'h4000 + 4*(n/32)), 32'd1 << (n%32), 1);
         wr(16'(16'h4180 + 4*(n/32)), 32'd1 << (n%32), 1);
      end
      rd(16'h4080, 1, q); chk("R4 pending word via clear bank", q, m_sw[31:0]);
      rd(16'h4004, 1, q); chk("R4 pending upper word", q, m_sw[63:32]);
      irq_chk("R10 pending irq");
      for (int k = 0; k < 11; k++) ev(1, "R6 R7 ascending drain");
      wr(16'h4080, 32'hFFFF_FFFF, 0);
      wr(16'h4084, 32'hFFFF_FFFF, 0);
      rd(16'h4000, 0, q); chk("R4 pending cleared", q, 32'd0);

      // IPIs and their precedence over lines
      wr(16'h3000 + 16'(4*5), 32'b1101, 0);
      wr(16'h4180, 32'd1 << 5, 0);
      hw[5] = 1;
      wr(16'h2008, 32'b0110, 0);
      irq_chk("R8 R10 ipi raises irq");
      ev(2, "R8 ipi first");
      ev(2, "R9 ipi masked then line");
      irq_chk("R9 masked ipi quiet");
      ev(0, "R5 shared line to core0");
      wr(16'h2028, 32'd1, 2);
      irq_chk("R9 unmask brings ipi back");
      ev(2, "R9 ipi again after unmask");
      wr(16'h200C, 32'd1, 2);
      wr(16'h2028, 32'd1, 2);
      ev(2, "R9 ack cleared ipi");
      irq_chk("R10 after ack");
      ev(1, "R8 second core ipi");
      wr(16'h200C, 32'd1, 1);
      wr(16'h2028, 32'd1, 1);
      ev(1, "R11 core1 idle");
      irq_chk("R10 final");
      hw[5] = 0;

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule